// File: doc/BRIEF.md
# Dual-Mode PWM Timebase with Buffered Compare

This block is the time base for a single PWM channel. One counter advances on each cycle in which the prescaled clock enable `tick` is high. It runs in one of two counting modes. In sawtooth mode it counts up from zero to the period value and wraps to zero, which gives an edge-aligned pulse. In triangle mode it counts up to the period value and back down to zero, which gives a pulse centred on the valley of the count. The block outputs the live count, a falling-direction flag, and one-cycle strobes at the bottom and top turning points, so other channels or a sampling scheduler can lock onto the same carrier.

Software writes the duty value into a shadow register at any time. The value the comparator uses is copied from the shadow only on a cycle that carries a turning-point strobe, or while the counter is idle. A write therefore never cuts a pulse short in the middle of a period. The period register rule differs by mode. A sawtooth period of N clocks needs a period value of N-1. A triangle period of 2N clocks needs a period value of N.

The counter is a three-state machine with the states `ST_IDLE`, `ST_RISE` and `ST_FALL`:
- Start: `ST_IDLE` goes to `ST_RISE` when `en` is high and the period is non-zero.
- Stop: `ST_RISE` and `ST_FALL` both go to `ST_IDLE` when that condition is lost.
- Turn-down: in triangle mode, `ST_RISE` goes to `ST_FALL` on a tick at the top.
- Turn-up: `ST_FALL` goes to `ST_RISE` on a tick at zero in triangle mode, or on any tick in sawtooth mode.
- Wrap: in sawtooth mode, `ST_RISE` stays in `ST_RISE` and the count returns to zero.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `pwm_out`, `dir_down`, `zero_stb` and `prd_stb` are all 0.
- R2: In sawtooth mode (`mode`=0) the count steps 0, 1, …, P and then returns to 0. One period lasts P+1 ticks.
- R3: In triangle mode (`mode`=1) the count rises from 0 to P and then falls back to 0. One period lasts 2P ticks, and `dir_down` is 1 for exactly P of those ticks (the falling values P-1 down to 0).
- R4: `zero_stb` is 1 on a tick cycle in which the running count is 0. `prd_stb` is 1 on a tick cycle in which the running count is at or above P, while rising (triangle mode) or in any state (sawtooth mode). The two strobes are never high together, and each lasts one cycle per turning point.
- R5: In sawtooth mode `pwm_out` is 1 while the count is below the active compare value C. High cycles per period are min(C, P+1): C=0 gives 0% duty and C>P gives 100% duty.
- R6: In triangle mode `pwm_out` is 1 while rising with 0<C and count≤C, and while falling with count<C. High cycles per period are 2·min(C, P): C=0 gives 0% duty and C≥P gives 100% duty.
- R7: A pulse on `cmp_wr` loads `cmp_data` into the shadow register. The active compare value takes the shadow only on a cycle in which `zero_stb` or `prd_stb` is 1, or while idle. A mid-period write does not change `pwm_out` before the next strobe.
- R8: When `en` is 0 or P is 0, on the next clock the count is 0, the machine is idle, and `pwm_out`, `dir_down` and both strobes are 0. On restart, counting begins rising from 0.
- R9: On a running cycle in which `tick` is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| tick | input | 1 | Prescaled count enable |
| mode | input | 1 | 0 = sawtooth, 1 = triangle |
| period | input | CNT_W | Period value P |
| cmp_wr | input | 1 | Shadow compare write strobe |
| cmp_data | input | CNT_W | Shadow compare write data |
| pwm_out | output | 1 | PWM pulse |
| count | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 while counting down |
| zero_stb | output | 1 | Bottom turning-point strobe |
| prd_stb | output | 1 | Top turning-point strobe |

## Verification
The bench measures full periods between strobes. An off-by-one in the period rule would show up as P or P+2 sawtooth ticks, or as 2P±1 triangle ticks. It tests compare values of zero, exactly P, and above P: a comparator using the wrong relation would leave one stray high or low cycle and so miss 0% or 100% duty. It writes the shadow mid-fall and checks that the pulse keeps its old width until the next strobe, which catches a buffer that loads on every write. It also drops the period to zero and drops the enable mid-run, which catches a counter that keeps running or leaves the output high.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } ptb_state_e;
endpackage

// File: rtl/ptb_sequencer.sv
module ptb_sequencer
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             tri_mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output ptb_state_e       state,
    output logic             zero_stb,
    output logic             prd_stb
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_STEP = {{(CNT_W-1){1'b0}}, 1'b1};

    ptb_state_e       nxt_state;
    logic [CNT_W-1:0] nxt_count;
    logic             go;
    logic             at_zero;
    logic             at_top;

    assign go      = en && (period != CNT_ZERO);
    assign at_zero = (count == CNT_ZERO);
    assign at_top  = (count >= period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= CNT_ZERO;
        end else begin
            state <= nxt_state;
            count <= nxt_count;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_count = count;
        zero_stb  = 1'b0;
        prd_stb   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nxt_count = CNT_ZERO;
                if (go) nxt_state = ST_RISE;
            end
            ST_RISE: begin
                if (!go) begin
                    nxt_state = ST_IDLE;
                    nxt_count = CNT_ZERO;
                end else if (tick) begin
                    zero_stb = at_zero;
                    prd_stb  = at_top;
                    if (at_top) begin
                        if (tri_mode) begin
                            nxt_state = ST_FALL;
                            nxt_count = count - CNT_STEP;
                        end else begin
                            nxt_count = CNT_ZERO;
                        end
                    end else begin
                        nxt_count = count + CNT_STEP;
                    end
                end
            end
            ST_FALL: begin
                if (!go) begin
                    nxt_state = ST_IDLE;
                    nxt_count = CNT_ZERO;
                end else if (tick) begin
                    zero_stb = at_zero;
                    if (!tri_mode) begin
                        nxt_state = ST_RISE;
                        prd_stb   = at_top;
                        nxt_count = at_top ? CNT_ZERO : count + CNT_STEP;
                    end else if (at_zero) begin
                        nxt_state = ST_RISE;
                        nxt_count = CNT_STEP;
                    end else begin
                        nxt_count = count - CNT_STEP;
                    end
                end
            end
            default: begin
                nxt_state = ST_IDLE;
                nxt_count = CNT_ZERO;
            end
        endcase
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && go && !tick) |=> $stable(count)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (count == CNT_ZERO && state == ST_IDLE)); // R8
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({zero_stb, prd_stb})); // R4
    AST_ZERO_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        zero_stb |=> !zero_stb); // R4
    AST_PRD_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        prd_stb |=> !prd_stb); // R4
endmodule

// File: rtl/ptb_cmp_buffer.sv
module ptb_cmp_buffer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             reload,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr)     shadow <= wdata;
            if (reload) active <= shadow;
        end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(active)); // R7
endmodule

// File: rtl/ptb_pwm_out.sv
module ptb_pwm_out
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  ptb_state_e       state,
    input  logic             tri_mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] active,
    output logic             pwm
);
    always_comb begin
        pwm = 1'b0;
        unique case (state)
            ST_IDLE: pwm = 1'b0;
            ST_RISE: pwm = tri_mode ? ((active != '0) && (count <= active))
                                    : (count < active);
            ST_FALL: pwm = (count < active);
            default: pwm = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             mode,
    input  logic [CNT_W-1:0] period,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             zero_stb,
    output logic             prd_stb
);
    ptb_state_e       state;
    logic [CNT_W-1:0] act_cmp;
    logic             reload;

    ptb_sequencer #(.CNT_W(CNT_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .tri_mode (mode),
        .period   (period),
        .count    (count),
        .state    (state),
        .zero_stb (zero_stb),
        .prd_stb  (prd_stb)
    );

    assign reload = zero_stb || prd_stb || (state == ST_IDLE);

    ptb_cmp_buffer #(.CNT_W(CNT_W)) i_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmp_wr),
        .wdata  (cmp_data),
        .reload (reload),
        .active (act_cmp)
    );

    ptb_pwm_out #(.CNT_W(CNT_W)) i_out (
        .state    (state),
        .tri_mode (mode),
        .count    (count),
        .active   (act_cmp),
        .pwm      (pwm_out)
    );

    assign dir_down = (state == ST_FALL);

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cmp == '0) |-> !pwm_out); // R6
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!dir_down && !pwm_out && !zero_stb && !prd_stb)); // R8
endmodule

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tick = 1'b1;
    logic        mode = 1'b0;
    logic [15:0] period = 16'd0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_data = 16'd0;
    logic        pwm_out, dir_down, zero_stb, prd_stb;
    logic [15:0] count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";
    int div = 1;
    int ph = 0;
    int s_cnt;
    bit s_pwm, s_dir, s_zero, s_prd;

    logic [1:0]  m_st;
    logic [15:0] m_cnt, m_shd, m_act;
    logic        e_zero, e_prd, e_pwm, m_go;

    always #2.5 clk = ~clk;

    pwm_timebase #(.CNT_W(16)) i_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .mode(mode),
        .period(period), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .pwm_out(pwm_out), .count(count), .dir_down(dir_down),
        .zero_stb(zero_stb), .prd_stb(prd_stb)
    );

    // Reference model of the requirements (states 0 idle, 1 rising, 2 falling)
    always_comb begin
        m_go   = en && (period != 16'd0);
        e_zero = (m_st != 2'd0) && m_go && tick && (m_cnt == 16'd0);
        e_prd  = (m_st != 2'd0) && m_go && tick && (m_cnt >= period) && (!mode || m_st == 2'd1);
        if (m_st == 2'd0)      e_pwm = 1'b0;
        else if (!mode)        e_pwm = m_cnt < m_act;
        else if (m_st == 2'd2) e_pwm = m_cnt < m_act;
        else                   e_pwm = (m_act != 16'd0) && (m_cnt <= m_act);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 2'd0; m_cnt <= 16'd0; m_shd <= 16'd0; m_act <= 16'd0;
        end else begin
            if (cmp_wr) m_shd <= cmp_data;
            if (e_zero || e_prd || m_st == 2'd0) m_act <= m_shd;
            if (!m_go) begin
                m_st <= 2'd0; m_cnt <= 16'd0;
            end else if (m_st == 2'd0) begin
                m_st <= 2'd1;
            end else if (tick) begin
                if (!mode) begin
                    m_st <= 2'd1;
                    m_cnt <= (m_cnt >= period) ? 16'd0 : m_cnt + 16'd1;
                end else if (m_st == 2'd1) begin
                    if (m_cnt >= period) begin m_st <= 2'd2; m_cnt <= m_cnt - 16'd1; end
                    else m_cnt <= m_cnt + 16'd1;
                end else begin
                    if (m_cnt == 16'd0) begin m_st <= 2'd1; m_cnt <= 16'd1; end
                    else m_cnt <= m_cnt - 16'd1;
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        s_cnt = int'(count); s_pwm = pwm_out; s_dir = dir_down;
        s_zero = zero_stb; s_prd = prd_stb;
        if (rst_n) begin
            chk({tag, " count"}, s_cnt, int'(m_cnt));
            chk({tag, " pwm"}, int'(s_pwm), int'(e_pwm));
            chk({tag, " dir"}, int'(s_dir), int'(m_st == 2'd2));
            chk({tag, " zero_stb"}, int'(s_zero), int'(e_zero));
            chk({tag, " prd_stb"}, int'(s_prd), int'(e_prd));
        end
        ph = (ph + 1) % div;
        tick = (ph == 0);
    endtask

    task automatic wr(int v);
        cmp_data = 16'(v); cmp_wr = 1'b1;
        cyc();
        cmp_wr = 1'b0;
    endtask

    task automatic measure(output int len, output int high, output int down, output int prds);
        int g = 0;
        do begin cyc(); g++; end while (!s_zero && g < 500);
        len = 1; high = int'(s_pwm); down = int'(s_dir); prds = int'(s_prd);
        for (int i = 0; i < 500; i++) begin
            cyc();
            if (s_zero) break;
            len++; high += int'(s_pwm); down += int'(s_dir); prds += int'(s_prd);
        end
    endtask

    task automatic setup(bit m, int p, int c, int d);
        en = 1'b0; cyc();
        mode = m; period = 16'(p); div = d; ph = 0; tick = 1'b1;
        wr(c);
        en = 1'b1;
    endtask

    task automatic t_reset();
        tag = "R1";
        @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 pwm", int'(pwm_out), 0);
        chk("R1 dir", int'(dir_down), 0);
        chk("R1 strobes", int'(zero_stb) + int'(prd_stb), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_saw();
        int len, high, down, prds;
        int cs[3] = '{2, 0, 9};
        int ex[3] = '{2, 0, 5};
        for (int k = 0; k < 3; k++) begin
            tag = "R2";
            setup(1'b0, 4, cs[k], 1);
            measure(len, high, down, prds);
            measure(len, high, down, prds);
            chk("R2 saw period", len, 5);
            chk("R4 saw prd strobes per period", prds, 1);
            chk("R5 saw high cycles", high, ex[k]);
        end
    endtask

    task automatic t_tri();
        int len, high, down, prds;
        int cs[4] = '{2, 5, 7, 0};
        int ex[4] = '{4, 10, 10, 0};
        for (int k = 0; k < 4; k++) begin
            tag = "R3";
            setup(1'b1, 5, cs[k], 1);
            measure(len, high, down, prds);
            measure(len, high, down, prds);
            chk("R3 tri period", len, 10);
            chk("R3 tri falling cycles", down, 5);
            chk("R4 tri prd strobes per period", prds, 1);
            chk("R6 tri high cycles", high, ex[k]);
        end
    endtask

    task automatic t_tick();
        int len, high, down, prds;
        tag = "R9";
        setup(1'b0, 3, 1, 3);
        measure(len, high, down, prds);
        measure(len, high, down, prds);
        chk("R9 saw period with tick every third cycle", len, 12);
        chk("R9 high cycles with slow tick", high, 3);
    endtask

    task automatic t_shadow();
        int len, high, down, prds;
        int g = 0;
        tag = "R7";
        setup(1'b1, 6, 2, 1);
        measure(len, high, down, prds);
        do begin cyc(); g++; end while (!s_prd && g < 100);
        cyc(); cyc();
        wr(5);
        chk("R7 count at mid-fall write", s_cnt, 3);
        chk("R7 pwm keeps old compare after write", int'(s_pwm), 0);
        measure(len, high, down, prds);
        chk("R7 new compare after reload", high, 10);
    endtask

    task automatic t_idle();
        int len, high, down, prds;
        tag = "R8";
        setup(1'b0, 4, 2, 1);
        measure(len, high, down, prds);
        period = 16'd0;
        for (int i = 0; i < 5; i++) begin
            cyc();
            chk("R8 zero period count", s_cnt, 0);
            chk("R8 zero period pwm", int'(s_pwm) + int'(s_zero) + int'(s_prd), 0);
        end
        period = 16'd4;
        measure(len, high, down, prds);
        chk("R8 restart period", len, 5);
        chk("R8 restart high", high, 2);
        mode = 1'b1;
        for (int i = 0; i < 7; i++) cyc();
        en = 1'b0;
        cyc();
        chk("R8 disable count", s_cnt, 0);
        chk("R8 disable dir", int'(s_dir), 0);
        chk("R8 disable pwm", int'(s_pwm), 0);
    endtask

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_saw();
        t_tri();
        t_tick();
        t_shadow();
        t_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule